// File: doc/BRIEF.md
# Boot ROM Shadowing Address Decoder

This block decodes a 22-bit address bus with an 8-bit data path. RAM is treated as covering the whole map. The decoder therefore asserts a RAM select for any address it does not claim for something else. It claims two places: a 64 KB boot window at the bottom of the map, and a single control register address.

After reset the boot window runs in copy mode. Reads in the window go to the ROM. Writes to the same addresses go to the RAM underneath. Start-up code reads every window address and writes the value back, so the RAM ends up holding a copy of the ROM. Software then sets the shadow bit in the control register. From that point reads in the window come from RAM, the ROM is never selected, and writes to the window are dropped. A second control bit lifts this write protection for as long as software needs to patch the copy.

Every select is gated by the CPU address strobe. A one-cycle-delayed acknowledge ends each bus cycle. Writes that the protection blocks are acknowledged in the same way.

Top module: `shadow_decoder`

## Requirements
- R1: With the strobe active and an address that is outside the boot window (upper six address bits not all zero) and not the control address, ram_sel is 1, rom_sel and ctl_sel are 0, and ram_we equals 1 exactly when the access is a write (bus_rd = 0).
- R2: Right after reset the control register reads 0x00, and a read in the boot window selects the ROM.
- R3: In copy mode (control bit0 = 0), a window read asserts rom_sel only. A window write asserts ram_sel and ram_we, and never rom_sel.
- R4: The control register is at CTL_ADDR (default 0x3FFF00). An access there asserts only ctl_sel. A write loads all eight bits at the next clock edge. A read returns the stored byte on ctl_rdata, and ctl_rdata is 0x00 on every other cycle. Bit0 enables shadow mode and bit1 unlocks writes.
- R5: In shadow mode (bit0 = 1), rom_sel is never asserted. A window read asserts ram_sel with ram_we = 0.
- R6: In shadow mode with bit1 = 0, a window write asserts neither ram_sel nor ram_we.
- R7: In shadow mode with bit1 = 1, a window write asserts ram_sel and ram_we.
- R8: bus_ack is high in the cycle after each clock edge at which the strobe was sampled high, including blocked writes. Otherwise it is low.
- R9: While bus_as is 0, rom_sel, ram_sel, ram_we and ctl_sel are all 0.
- R10: Reset clears the control register, whatever it held, so the decoder returns to copy mode with writes locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_as | input | 1 | Address strobe, active high |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 22 | Byte address |
| bus_wdata | input | 8 | Write data |
| rom_sel | output | 1 | Boot ROM select |
| ram_sel | output | 1 | RAM select |
| ram_we | output | 1 | RAM write strobe |
| ctl_sel | output | 1 | Control register select |
| ctl_rdata | output | 8 | Control register read data |
| bus_ack | output | 1 | Cycle acknowledge |

## Verification
The hardest case to reach is a write into the window that lands while shadow mode is on and the unlock bit is either set or clear. Reaching it needs an earlier control write that stays in effect. The random stimulus therefore mixes control-register writes with random bit patterns into accesses biased towards the window, so every mode combination meets both transfer directions. A directed sequence loads the control register with shadow and unlock set, then applies reset, to show that the lock comes back.

// File: rtl/shd_pkg.sv
package shd_pkg;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        REG_RAM = 2'd0,
        REG_WIN = 2'd1,
        REG_CTL = 2'd2
    } region_e;

    typedef struct packed {
        logic [DATA_W-3:0] spare;
        logic              unlock;
        logic              shadow;
    } ctl_t;

    typedef struct packed {
        logic rom;
        logic ram;
        logic we;
        logic ctl;
    } sel_t;
endpackage

// File: rtl/shd_region_dec.sv
module shd_region_dec #(
    parameter int          ADDR_W   = 22,
    parameter int          WIN_BITS = 16,
    parameter logic [21:0] CTL_ADDR = 22'h3FFF00
) (
    input  logic [ADDR_W-1:0] addr,
    output shd_pkg::region_e  region
);
    import shd_pkg::*;
    localparam int HI_W = ADDR_W - WIN_BITS;

    logic in_win;
    assign in_win = (addr[ADDR_W-1:WIN_BITS] == {HI_W{1'b0}});

    always_comb begin
        if (addr == CTL_ADDR[ADDR_W-1:0]) region = REG_CTL;
        else if (in_win)                  region = REG_WIN;
        else                              region = REG_RAM;
    end
endmodule

// File: rtl/shd_mode_reg.sv
module shd_mode_reg (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_stb,
    input  logic [shd_pkg::DATA_W-1:0]    wdata,
    output shd_pkg::ctl_t                 ctl_q
);
    import shd_pkg::*;
    ctl_t ctl_d;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_stb) ctl_d = ctl_t'(wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // R10: the cycle after reset is released, the register holds zero unless a write came in
    p_reset_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && !$past(wr_stb)) |-> (ctl_q == '0));
endmodule

// File: rtl/shd_select.sv
module shd_select (
    input  logic              as_i,
    input  logic              rd_i,
    input  shd_pkg::region_e  region,
    input  shd_pkg::ctl_t     ctl,
    output shd_pkg::sel_t     sel
);
    import shd_pkg::*;

    always_comb begin
        sel = '0;
        if (as_i) begin
            unique case (region)
                REG_CTL: sel.ctl = 1'b1;
                REG_WIN: begin
                    if (!ctl.shadow) begin
                        if (rd_i) sel.rom = 1'b1;
                        else begin
                            sel.ram = 1'b1;
                            sel.we  = 1'b1;
                        end
                    end else begin
                        if (rd_i) sel.ram = 1'b1;
                        else if (ctl.unlock) begin
                            sel.ram = 1'b1;
                            sel.we  = 1'b1;
                        end
                    end
                end
                default: begin
                    sel.ram = 1'b1;
                    sel.we  = !rd_i;
                end
            endcase
        end
    end
endmodule

// File: rtl/shadow_decoder.sv
module shadow_decoder #(
    parameter int          ADDR_W   = 22,
    parameter int          WIN_BITS = 16,
    parameter logic [21:0] CTL_ADDR = 22'h3FFF00
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_as,
    input  logic                       bus_rd,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [shd_pkg::DATA_W-1:0] bus_wdata,
    output logic                       rom_sel,
    output logic                       ram_sel,
    output logic                       ram_we,
    output logic                       ctl_sel,
    output logic [shd_pkg::DATA_W-1:0] ctl_rdata,
    output logic                       bus_ack
);
    import shd_pkg::*;

    typedef struct packed {
        logic ack;
    } st_t;

    region_e region;
    ctl_t    ctl_q;
    sel_t    sel;
    st_t     st_d, st_q;
    logic    ctl_wr;

    shd_region_dec #(
        .ADDR_W  (ADDR_W),
        .WIN_BITS(WIN_BITS),
        .CTL_ADDR(CTL_ADDR)
    ) u_dec (
        .addr  (bus_addr),
        .region(region)
    );

    assign ctl_wr = bus_as && !bus_rd && (region == REG_CTL);

    shd_mode_reg u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_stb(ctl_wr),
        .wdata (bus_wdata),
        .ctl_q (ctl_q)
    );

    shd_select u_sel (
        .as_i  (bus_as),
        .rd_i  (bus_rd),
        .region(region),
        .ctl   (ctl_q),
        .sel   (sel)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ack = bus_as;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rom_sel   = sel.rom;
    assign ram_sel   = sel.ram;
    assign ram_we    = sel.we;
    assign ctl_sel   = sel.ctl;
    assign bus_ack   = st_q.ack;
    assign ctl_rdata = (sel.ctl && bus_rd) ? DATA_W'(ctl_q) : '0;

    p_no_contention_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(rom_sel && ram_sel));
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_as |-> !(rom_sel || ram_sel || ram_we || ctl_sel));
    p_shadow_no_rom_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.shadow |-> !rom_sel);
    p_locked_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.shadow && !ctl_q.unlock && !bus_rd && region == REG_WIN) |-> !ram_we);
    p_ack_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_as |=> bus_ack);
    p_we_needs_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_sel && !bus_rd));
endmodule

// File: tb/shadow_decoder_test.sv
module shadow_decoder_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [21:0] CTL_A = 22'h3FFF00;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_as = 1'b0, bus_rd = 1'b1;
    logic [21:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic rom_sel, ram_sel, ram_we, ctl_sel, bus_ack;
    logic [7:0] ctl_rdata;

    int checks = 0, failures = 0;
    bit done = 1'b0;
    logic [7:0] m_ctl = 8'h00;
    logic prev_as = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shadow_decoder uut (
        .clk(clk), .rst_n(rst_n), .bus_as(bus_as), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rom_sel(rom_sel),
        .ram_sel(ram_sel), .ram_we(ram_we), .ctl_sel(ctl_sel),
        .ctl_rdata(ctl_rdata), .bus_ack(bus_ack)
    );

    function automatic logic [3:0] exp_sel(logic as_i, logic rd, logic [21:0] a, logic [7:0] c);
        if (!as_i) return 4'b0000;
        if (a == CTL_A) return 4'b0001;
        if (a[21:16] == 6'd0) begin
            if (!c[0]) return rd ? 4'b1000 : 4'b0110;
            if (rd) return 4'b0100;
            return c[1] ? 4'b0110 : 4'b0000;
        end
        return rd ? 4'b0100 : 4'b0110;
    endfunction

    function automatic string tag(logic as_i, logic rd, logic [21:0] a, logic [7:0] c);
        if (!as_i) return "R9";
        if (a == CTL_A) return "R4";
        if (a[21:16] != 6'd0) return "R1";
        if (!c[0]) return "R3";
        if (rd) return "R5";
        return c[1] ? "R7" : "R6";
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive at negedge, check combinational outputs 1 time unit later
    task automatic access(logic as_i, logic rd, logic [21:0] a, logic [7:0] d);
        @(negedge clk);
        chk("R8", {31'd0, bus_ack}, {31'd0, prev_as});
        bus_as = as_i; bus_rd = rd; bus_addr = a; bus_wdata = d;
        #1;
        chk(tag(as_i, rd, a, m_ctl), {28'd0, rom_sel, ram_sel, ram_we, ctl_sel},
            {28'd0, exp_sel(as_i, rd, a, m_ctl)});
        chk("R4", {24'd0, ctl_rdata}, (as_i && rd && a == CTL_A) ? {24'd0, m_ctl} : 32'd0);
        prev_as = as_i;
        if (as_i && !rd && a == CTL_A) m_ctl = d;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R2: reset state
        access(1'b1, 1'b1, CTL_A, 8'h00);
        chk("R2", {31'd0, ctl_rdata}, 32'd0);
        access(1'b1, 1'b1, 22'h000100, 8'h00);
        chk("R2", {31'd0, rom_sel}, 32'd1);
        access(1'b0, 1'b1, 22'h000100, 8'h00);
        // R3 copy pass at window edges
        access(1'b1, 1'b1, 22'h00FFFF, 8'h00);
        access(1'b1, 1'b0, 22'h00FFFF, 8'h5A);
        access(1'b1, 1'b0, 22'h010000, 8'h5A);
        // R5/R6: shadow locked
        access(1'b1, 1'b0, CTL_A, 8'h01);
        access(1'b1, 1'b1, 22'h000000, 8'h00);
        access(1'b1, 1'b0, 22'h000000, 8'hAA);
        chk("R6", {30'd0, ram_sel, ram_we}, 32'd0);
        access(1'b0, 1'b1, 22'h000000, 8'h00);
        // R8: blocked write still acknowledged (prev_as=1 check occurs above)
        // R7: unlock
        access(1'b1, 1'b0, CTL_A, 8'h03);
        access(1'b1, 1'b0, 22'h001234, 8'h11);
        chk("R7", {31'd0, ram_we}, 32'd1);
        access(1'b1, 1'b1, CTL_A, 8'h00);
        // R10: reset while shadow+unlock set
        @(negedge clk) rst_n = 1'b0; bus_as = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1; prev_as = 1'b0; m_ctl = 8'h00;
        access(1'b1, 1'b1, CTL_A, 8'h00);
        chk("R10", {24'd0, ctl_rdata}, 32'd0);
        access(1'b1, 1'b1, 22'h000040, 8'h00);
        chk("R10", {31'd0, rom_sel}, 32'd1);
        // random mix
        for (int i = 0; i < 600; i++) begin
            int unsigned pick = $urandom_range(0, 99);
            logic [21:0] a;
            logic as_i = ($urandom_range(0, 9) != 0);
            logic rd = $urandom_range(0, 1);
            logic [7:0] d = 8'($urandom);
            if (pick < 10) a = CTL_A;
            else if (pick < 60) a = {6'd0, 16'($urandom)};
            else a = 22'($urandom);
            access(as_i, rd, a, d);
        end
        access(1'b0, 1'b1, 22'h0, 8'h0);
        @(negedge clk);
        chk("R8", {31'd0, bus_ack}, 32'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule